// File: doc/BRIEF.md
# Double-Buffered DAC Bus Interface

This block is the processor-facing register interface of a 16-bit digital-to-analog converter. A host reaches it over a 16-bit parallel data bus. An active-low select and a read/write line let the host write a word into a staging register, called the input latch, or read that register back. A separate active-low load strobe copies the staged word into the converter register, which drives the converter. Several converters can therefore be updated together by sharing one load line. An active-low clear forces the converter register to zero or to midscale. The level of the read/write line picks which of the two, so one clear line can bring the output to 0 V in either a unipolar or a bipolar setup.

All four control lines are asynchronous to the system clock and pass through two-flop synchronizers. Every latch action uses the synchronized levels. The bus is split into an input word, an output word and an output-enable; the chip's pad ring merges these into one tri-state bus. On each falling edge of the load strobe the block raises a hold signal for a fixed number of clocks. This signal freezes the output track-and-hold while the converter settles. The hold length is derived from the clock frequency and a hold time in nanoseconds.

Top module: `dac_bus_if`

## Requirements
- R1: While the select input has been high at the last two clock edges, `bus_oe` is low whatever the other inputs are.
- R2: Select low with read/write low writes `bus_in` into the input latch on each clock edge while that synchronized condition holds.
- R3: Select low with read/write high raises `bus_oe` and drives the input latch on `bus_out`.
- R4: Load low with clear high copies the input latch into the converter register, whatever the select level.
- R5: Clear low with read/write low sets the converter register to 0x0000.
- R6: Clear low with read/write high sets the converter register to 0x8000 (only the most significant bit set).
- R7: When clear and load are both low, clear wins.
- R8: A falling edge of the synchronized load strobe raises `hold` for exactly HOLD_CYC clock cycles, with HOLD_CYC = ceil(HOLD_NS * CLK_MHZ / 1000) (625 at the defaults).
- R9: A new load falling edge during a hold interval restarts the full count.
- R10: If load is low from reset onward, the converter register follows the input latch and `hold` never rises.
- R11: An input change made between two clock edges reaches the outputs after exactly two rising edges: the synchronized level is valid after the second edge, and a latch write takes effect at the third.
- R12: After reset the input latch and converter register are 0x0000, and `hold` and `bus_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select for bus access |
| rw | input | 1 | 1 = read back, 0 = write; also picks the clear value |
| ld_n | input | 1 | Active-low transfer strobe into the converter register |
| clr_n | input | 1 | Active-low clear of the converter register |
| bus_in | input | W | Data from the host bus |
| bus_out | output | W | Readback data toward the host bus |
| bus_oe | output | 1 | Enable for the bus drivers |
| dac_code | output | W | Converter register contents |
| hold | output | 1 | 1 = output stage holds, 0 = tracks |

## Verification
The comparison rule follows from the pipeline. A control input takes effect on the outputs only after two rising edges. Output-enable and readback follow the second-stage synchronizer directly. The latches update on the edge after that, and `hold` rises one edge after the synchronized falling edge is seen. The bench model keeps a two-deep history of the inputs it samples on each rising edge. It applies that history in the same order and compares every output at the falling edge, where nothing is changing. Targeted checks count exact cycles for the synchronizer delay and for the length of the hold window, including a restart.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;
   // control bit positions inside the synchronized vector
   localparam int CTL_CS  = 0;
   localparam int CTL_RW  = 1;
   localparam int CTL_LD  = 2;
   localparam int CTL_CLR = 3;
   localparam int CTL_N   = 4;

   // hold interval in clock cycles, rounded up
   function automatic int hold_cycles(input int clk_mhz, input int hold_ns);
      return (hold_ns * clk_mhz + 999) / 1000;
   endfunction
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
   parameter int             N      = 4,
   parameter int             STAGES = 2,
   parameter logic [N-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbi_sync needs at least two stages");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST[i]}};
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end
endmodule

// File: rtl/dbi_latches.sv
module dbi_latches #(
   parameter int W = 16,
   localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_cs_n,
   input  logic         s_rw,
   input  logic         s_ld_n,
   input  logic         s_clr_n,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] in_q,
   output logic [W-1:0] dac_q
);
   logic wr_en;
   assign wr_en = !s_cs_n && !s_rw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_q <= '0;
      else if (wr_en) in_q <= bus_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dac_q <= '0;
      else if (!s_clr_n)  dac_q <= s_rw ? MID : '0;
      else if (!s_ld_n)   dac_q <= in_q;
   end

   // R2
   wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_cs_n && !s_rw) |=> in_q == $past(bus_in));
   // R4
   ld_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_clr_n && !s_ld_n) |=> dac_q == $past(in_q));
   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_clr_n && !s_rw) |=> dac_q == '0);
   // R6
   clr_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_clr_n && s_rw) |=> dac_q == MID);
endmodule

// File: rtl/dbi_hold.sv
module dbi_hold #(
   parameter int CYC = 625,
   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_ld_n,
   output logic hold
);
   if (CYC == 0) begin : g_none
      logic unused_ld;
      assign unused_ld = s_ld_n;
      assign hold = 1'b0;
   end else begin : g_timer
      logic          ld_prev;
      logic          fall;
      logic [CW-1:0] cnt;

      // reset low so a strobe tied low from reset yields no edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ld_prev <= 1'b0;
         else        ld_prev <= s_ld_n;
      end
      assign fall = ld_prev && !s_ld_n;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (fall)       cnt <= CW'(CYC);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign hold = (cnt != '0);

      // R8
      hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fall |=> hold);
      // R8
      hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(CYC));
      // R9
      hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fall && hold) |=> cnt == CW'(CYC));
   end
endmodule

// File: rtl/dac_bus_if.sv
module dac_bus_if
   import dac_bus_pkg::*;
#(
   parameter int W           = 16,
   parameter int CLK_MHZ     = 250,
   parameter int HOLD_NS     = 2500,
   parameter int SYNC_STAGES = 2,
   localparam int HOLD_CYC   = hold_cycles(CLK_MHZ, HOLD_NS)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         rw,
   input  logic         ld_n,
   input  logic         clr_n,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] bus_out,
   output logic         bus_oe,
   output logic [W-1:0] dac_code,
   output logic         hold
);
   if (W < 2) begin : g_bad_w
      $error("dac_bus_if needs W >= 2");
   end
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("dac_bus_if needs CLK_MHZ >= 1");
   end

   // reset levels: select and clear inactive, load low, rw write
   localparam logic [CTL_N-1:0] CTL_RST = 4'b1001;

   logic [CTL_N-1:0] ctl_raw, ctl_s;
   logic [W-1:0]     in_q;

   assign ctl_raw[CTL_CS]  = cs_n;
   assign ctl_raw[CTL_RW]  = rw;
   assign ctl_raw[CTL_LD]  = ld_n;
   assign ctl_raw[CTL_CLR] = clr_n;

   dbi_sync #(.N(CTL_N), .STAGES(SYNC_STAGES), .RST(CTL_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
   );

   dbi_latches #(.W(W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .s_cs_n(ctl_s[CTL_CS]), .s_rw(ctl_s[CTL_RW]),
      .s_ld_n(ctl_s[CTL_LD]), .s_clr_n(ctl_s[CTL_CLR]),
      .bus_in(bus_in), .in_q(in_q), .dac_q(dac_code)
   );

   dbi_hold #(.CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .s_ld_n(ctl_s[CTL_LD]), .hold(hold)
   );

   assign bus_oe  = !ctl_s[CTL_CS] && ctl_s[CTL_RW];
   assign bus_out = bus_oe ? in_q : '0;

   if (SYNC_STAGES == 2) begin : g_port_chk
      // R1
      cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cs_n, 2) |-> !bus_oe);
   end
   // R3
   rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (bus_out == in_q) && ctl_s[CTL_RW]);
endmodule

// File: tb/dac_bus_if_bench.sv
module dac_bus_if_bench;
   localparam int W = 16;
   localparam int H = 625;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rw = 1'b0, ld_n = 1'b0, clr_n = 1'b1;
   logic [W-1:0] bus_in = '0;
   logic [W-1:0] bus_out, dac_code;
   logic bus_oe, hold;

   always #2 clk = ~clk;

   dac_bus_if u_dac_bus_if (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n),
      .clr_n(clr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .dac_code(dac_code), .hold(hold)
   );

   int n_run = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R12";

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural reference: two-deep input history, state updated per edge
   logic [3:0] p1 = 4'b1001, p2 = 4'b1001; // {clr,ld,rw,cs}
   logic [W-1:0] m_in = '0, m_dac = '0;
   int  m_cnt = 0;
   bit  m_prev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         p1 = 4'b1001; p2 = 4'b1001; m_in = '0; m_dac = '0; m_cnt = 0; m_prev = 0;
      end else begin
         logic [W-1:0] old_in;
         old_in = m_in;
         if (!p2[0] && !p2[1]) m_in = bus_in;
         if (!p2[3])      m_dac = p2[1] ? 16'h8000 : 16'h0000;
         else if (!p2[2]) m_dac = old_in;
         if (m_prev && !p2[2]) m_cnt = H;
         else if (m_cnt > 0)   m_cnt = m_cnt - 1;
         m_prev = p2[2];
         p2 = p1;
         p1 = {clr_n, ld_n, rw, cs_n};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic exp_oe;
         exp_oe = !p2[0] && p2[1];
         chk({cur_req, " oe"}, {31'd0, bus_oe}, {31'd0, exp_oe});
         if (exp_oe) chk({cur_req, " readback"}, {16'd0, bus_out}, {16'd0, m_in});
         chk({cur_req, " dac"}, {16'd0, dac_code}, {16'd0, m_dac});
         chk({cur_req, " hold"}, {31'd0, hold}, {31'd0, (m_cnt != 0)});
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [W-1:0] v);
      bus_in = v; rw = 1'b0; cs_n = 1'b0; step(4); cs_n = 1'b1; step(3);
   endtask

   task automatic count_hold(input int max_c, output int c);
      c = 0;
      for (int i = 0; i < max_c; i++) begin step(1); if (hold) c++; end
   endtask

   int hc;

   initial begin
      step(5);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk("R12", {16'd0, dac_code}, 32'h0);
      chk("R12", {31'd0, hold}, 32'h0);
      chk("R12", {31'd0, bus_oe}, 32'h0);

      // R10 load tied low from reset: follows, no hold
      cur_req = "R10";
      bus_write(16'h1234);
      step(3);
      chk("R10", {16'd0, dac_code}, 32'h1234);
      bus_write(16'h5A5A);
      count_hold(5, hc);
      chk("R10", {16'd0, dac_code}, 32'h5A5A);
      chk("R10", hc, 0);
      ld_n = 1'b1;
      count_hold(6, hc);
      chk("R10", hc, 0);

      // R2 write, R3 readback, converter register untouched
      cur_req = "R2";
      bus_write(16'hBEEF);
      chk("R2", {16'd0, dac_code}, 32'h5A5A);
      cur_req = "R3";
      rw = 1'b1; cs_n = 1'b0; step(4);
      chk("R3", {31'd0, bus_oe}, 32'h1);
      chk("R3", {16'd0, bus_out}, 32'hBEEF);
      // R1 select high: bus released, bus changes ignored
      cur_req = "R1";
      cs_n = 1'b1; rw = 1'b0; bus_in = 16'h0F0F; step(4);
      chk("R1", {31'd0, bus_oe}, 32'h0);
      rw = 1'b1; step(3);
      chk("R1", {31'd0, bus_oe}, 32'h0);
      cs_n = 1'b0; step(3);
      chk("R1", {16'd0, bus_out}, 32'hBEEF);
      cs_n = 1'b1; step(3);

      // R11 latency of two rising edges
      cur_req = "R11";
      rw = 1'b1; cs_n = 1'b0; step(1);
      chk("R11", {31'd0, bus_oe}, 32'h0);
      step(1);
      chk("R11", {31'd0, bus_oe}, 32'h1);
      cs_n = 1'b1; step(3);

      // R4 load with select high, R8 hold length
      cur_req = "R4";
      ld_n = 1'b0; step(3); ld_n = 1'b1;
      chk("R4", {16'd0, dac_code}, 32'hBEEF);
      cur_req = "R8";
      count_hold(H + 20, hc);
      chk("R8", hc + 1, H); // one hold cycle already elapsed during the strobe
      // R9 restart: two falls 300 cycles apart
      cur_req = "R9";
      ld_n = 1'b0; step(3); ld_n = 1'b1; step(297);
      ld_n = 1'b0; step(3); ld_n = 1'b1;
      count_hold(H + 20, hc);
      chk("R9", hc + 1, H);

      // R5 clear to zero, R6 clear to midscale
      cur_req = "R5";
      rw = 1'b0; clr_n = 1'b0; step(3); clr_n = 1'b1; step(2);
      chk("R5", {16'd0, dac_code}, 32'h0);
      cur_req = "R6";
      rw = 1'b1; clr_n = 1'b0; step(3); clr_n = 1'b1; step(2);
      chk("R6", {16'd0, dac_code}, 32'h8000);
      // R7 clear wins over load
      cur_req = "R7";
      bus_write(16'h7777);
      rw = 1'b1; clr_n = 1'b0; ld_n = 1'b0; step(4);
      chk("R7", {16'd0, dac_code}, 32'h8000);
      clr_n = 1'b1; ld_n = 1'b1; step(3);
      chk("R7", {16'd0, dac_code}, 32'h8000);
      step(H + 10);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule